// File: doc/BRIEF.md
# Zero-Overhead Block Repeat Sequencer

This unit sits beside the fetch stage and lets a program repeat a block of instructions without spending any cycle on a branch. Software loads three values in one command: the address of the first instruction in the block, the address of the last one, and a repeat count. Loading also turns on repeat mode. While repeat mode is on, the unit compares each fetch address with the stored last address. When that address is fetched and repeats remain, the unit sends the next fetch back to the first address and decrements the count. When the count has run out, it lets the fetch fall through and turns repeat mode off.

The count is one-based on top of zero. A loaded value of n makes the block run n+1 times. The next-fetch address is combinational from the current fetch address and the stored state. The step strobe only decides whether the state moves on at the clock edge. A block of a single instruction, where the first and last addresses are equal, is handled like any other block.

Top module: `zol_ctrl`

## Requirements
- R1: After synchronous reset, `rpt_active_o` is 0, and `next_pc_o` equals `pc_i`+1 (modulo 2^24).
- R2: A cycle with `ld_i`=1 stores `ld_first_i`, `ld_last_i` and `ld_reps_i`, and sets `rpt_active_o` to 1 from the next cycle.
- R3: While `rpt_active_o` is 0, `next_pc_o` = `pc_i`+1 for every `pc_i`.
- R4: While repeat mode is on, `pc_i` equals the stored last address and the remaining count is nonzero, `next_pc_o` is the stored first address. A step in that cycle decrements the count by one.
- R5: A loaded count of n makes the last address be fetched n+1 times before the unit falls out of the loop. This includes n=0, which gives a single pass.
- R6: While repeat mode is on, `pc_i` equals the stored last address and the count is zero, `next_pc_o` = last+1. A step in that cycle clears `rpt_active_o` after the edge.
- R7: While repeat mode is on and `pc_i` differs from the stored last address, `next_pc_o` = `pc_i`+1 and no state changes.
- R8: With `step_i`=0 and `ld_i`=0, the count and the mode bit keep their values, even when `pc_i` is at the last address.
- R9: A block whose first and last addresses are equal runs n+1 times, and each pass returns to that same address.
- R10: When `ld_i` and a step at the last address fall in the same cycle, `next_pc_o` in that cycle follows the old block. The load then replaces all stored state, and the old block's count update is discarded.
- R11: Fall-through at last address 2^24-1 wraps `next_pc_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 24 | Address being fetched this cycle |
| step_i | input | 1 | A fetch at `pc_i` takes effect this cycle |
| ld_i | input | 1 | Load command for the block registers |
| ld_first_i | input | 24 | First address of the block |
| ld_last_i | input | 24 | Last address of the block |
| ld_reps_i | input | 32 | Repeat count (the block runs this value plus one times) |
| next_pc_o | output | 24 | Address of the next fetch |
| rpt_active_o | output | 1 | Repeat mode is on |

## Verification
Two functions can fall in the same cycle: a new load command, and a step at the last address of the block already running. The bench provokes this by starting a block with a large count and then asserting the load together with a step while `pc_i` sits on the old last address. The redirect seen in that cycle must point at the old first address. Afterwards, the new block must run exactly its own n+1 passes, which shows that the old count update was dropped.

// File: rtl/zol_pkg.sv
package zol_pkg;

    localparam int ADDR_W = 24;
    localparam int CNT_W  = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Routing decision for the next fetch
    typedef enum logic [1:0] {
        RT_SEQ  = 2'd0,   // plain sequential fetch
        RT_BACK = 2'd1,   // jump to block start, consume one repeat
        RT_EXIT = 2'd2    // last pass done, leave repeat mode
    } route_e;

    // Load command payload
    typedef struct packed {
        addr_t first;
        addr_t last;
        cnt_t  reps;
    } blk_cmd_t;

    // Live block state
    typedef struct packed {
        addr_t first;
        addr_t last;
        cnt_t  remain;
        logic  active;
    } blk_state_t;

    function automatic addr_t addr_inc(input addr_t a);
        return a + addr_t'(1);
    endfunction

    function automatic route_e pick_route(input logic active,
                                          input logic at_last,
                                          input logic spent);
        if (!active || !at_last) return RT_SEQ;
        if (spent)               return RT_EXIT;
        return RT_BACK;
    endfunction

endpackage

// File: rtl/zol_state_reg.sv
module zol_state_reg
    import zol_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ld,
    input  blk_cmd_t   cmd,
    input  logic       step,
    input  route_e     route,
    output blk_state_t st
);

    blk_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (ld) begin
            // a load overrides any update from the running block
            st_q.first  <= cmd.first;
            st_q.last   <= cmd.last;
            st_q.remain <= cmd.reps;
            st_q.active <= 1'b1;
        end else if (step) begin
            unique case (route)
                RT_BACK: st_q.remain <= st_q.remain - cnt_t'(1);
                RT_EXIT: st_q.active <= 1'b0;
                default: ;
            endcase
        end
    end

    assign st = st_q;

endmodule

// File: rtl/zol_end_detect.sv
module zol_end_detect
    import zol_pkg::*;
(
    input  addr_t      pc,
    input  blk_state_t st,
    output route_e     route
);

    logic at_last;
    logic spent;

    assign at_last = (pc == st.last);
    assign spent   = (st.remain == '0);
    assign route   = pick_route(st.active, at_last, spent);

endmodule

// File: rtl/zol_pc_select.sv
module zol_pc_select
    import zol_pkg::*;
(
    input  addr_t  pc,
    input  addr_t  first,
    input  route_e route,
    output addr_t  next_pc
);

    always_comb begin
        unique case (route)
            RT_BACK: next_pc = first;
            default: next_pc = addr_inc(pc);
        endcase
    end

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     pc_i,
    input  logic                  step_i,
    input  logic                  ld_i,
    input  logic [ADDR_W-1:0]     ld_first_i,
    input  logic [ADDR_W-1:0]     ld_last_i,
    input  logic [CNT_W-1:0]      ld_reps_i,
    output logic [ADDR_W-1:0]     next_pc_o,
    output logic                  rpt_active_o
);

    blk_cmd_t   cmd;
    blk_state_t st_q;
    route_e     route;

    assign cmd.first = ld_first_i;
    assign cmd.last  = ld_last_i;
    assign cmd.reps  = ld_reps_i;

    zol_state_reg u_state (
        .clk   (clk),
        .rst   (rst),
        .ld    (ld_i),
        .cmd   (cmd),
        .step  (step_i),
        .route (route),
        .st    (st_q)
    );

    zol_end_detect u_detect (
        .pc    (pc_i),
        .st    (st_q),
        .route (route)
    );

    zol_pc_select u_sel (
        .pc      (pc_i),
        .first   (st_q.first),
        .route   (route),
        .next_pc (next_pc_o)
    );

    assign rpt_active_o = st_q.active;

endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk
    import zol_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input addr_t pc_i,
    input logic  step_i,
    input logic  ld_i,
    input addr_t next_pc_o,
    input logic  rpt_active_o,
    input addr_t first,
    input addr_t last,
    input cnt_t  remain
);

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !rpt_active_o);

    a_r2_load_arms: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> rpt_active_o);

    a_r3_idle_seq: assert property (@(posedge clk) disable iff (rst)
        !rpt_active_o |-> next_pc_o == pc_i + addr_t'(1));

    a_r4_back_target: assert property (@(posedge clk) disable iff (rst)
        (rpt_active_o && pc_i == last && remain != '0) |-> next_pc_o == first);

    a_r4_count_dec: assert property (@(posedge clk) disable iff (rst)
        (step_i && !ld_i && rpt_active_o && pc_i == last && remain != '0)
        |=> (remain == $past(remain) - cnt_t'(1)) && rpt_active_o);

    a_r6_exit_clears: assert property (@(posedge clk) disable iff (rst)
        (step_i && !ld_i && rpt_active_o && pc_i == last && remain == '0)
        |=> !rpt_active_o);

    a_r7_inside_seq: assert property (@(posedge clk) disable iff (rst)
        (rpt_active_o && pc_i != last) |-> next_pc_o == pc_i + addr_t'(1));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !ld_i) |=> $stable(remain) && $stable(rpt_active_o));

endmodule

bind zol_ctrl zol_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc_i         (pc_i),
    .step_i       (step_i),
    .ld_i         (ld_i),
    .next_pc_o    (next_pc_o),
    .rpt_active_o (rpt_active_o),
    .first        (st_q.first),
    .last         (st_q.last),
    .remain       (st_q.remain)
);

// File: tb/zol_ctrl_test.sv
module zol_ctrl_test;
    import zol_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic  clk = 1'b0;
    logic  rst;
    addr_t pc_i;
    logic  step_i;
    logic  ld_i;
    addr_t ld_first_i;
    addr_t ld_last_i;
    cnt_t  ld_reps_i;
    addr_t next_pc_o;
    logic  rpt_active_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zol_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .pc_i         (pc_i),
        .step_i       (step_i),
        .ld_i         (ld_i),
        .ld_first_i   (ld_first_i),
        .ld_last_i    (ld_last_i),
        .ld_reps_i    (ld_reps_i),
        .next_pc_o    (next_pc_o),
        .rpt_active_o (rpt_active_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cycles, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load_block(input addr_t f, input addr_t l, input cnt_t n);
        ld_i = 1'b1; ld_first_i = f; ld_last_i = l; ld_reps_i = n;
        @(posedge clk); @(negedge clk);
        ld_i = 1'b0;
    endtask

    // Fetch through a block, stepping every cycle, and count passes over the last address
    task automatic run_block(input addr_t f, input addr_t l, input int n, input string req);
        addr_t pc = f;
        addr_t nxt;
        int hits = 0;
        bit route_ok = 1'b1;
        step_i = 1'b1;
        for (int g = 0; g < 2000; g++) begin
            pc_i = pc;
            #1;
            nxt = next_pc_o;
            if (pc == l) begin
                hits++;
                if (hits <= n && nxt != f) route_ok = 1'b0;
                if (hits == n + 1)
                    check(nxt == addr_inc(l), req, "fall-through address", nxt, addr_inc(l));
            end
            @(posedge clk); @(negedge clk);
            if (pc == l && hits == n + 1) break;
            pc = nxt;
        end
        step_i = 1'b0;
        check(route_ok, req, "every loop-back targets first", route_ok, 1);
        check(hits == n + 1, req, "passes over last address", hits, n + 1);
        check(rpt_active_o == 1'b0, req, "mode cleared after last pass", rpt_active_o, 0);
    endtask

    task automatic t_reset;
        pc_i = 24'h000123; #1;
        check(rpt_active_o == 1'b0, "R1", "mode after reset", rpt_active_o, 0);
        check(next_pc_o == 24'h000124, "R1", "next after reset", next_pc_o, 24'h000124);
    endtask

    task automatic t_idle;
        for (int i = 0; i < 3; i++) begin
            addr_t p = addr_t'(24'h0A0000 + i * 24'h111);
            pc_i = p; step_i = 1'b1; #1;
            check(next_pc_o == addr_inc(p), "R3", "idle sequential", next_pc_o, addr_inc(p));
            @(posedge clk); @(negedge clk);
        end
        step_i = 1'b0;
    endtask

    task automatic t_basic;
        load_block(24'h000100, 24'h000103, 32'd2);
        check(rpt_active_o == 1'b1, "R2", "mode after load", rpt_active_o, 1);
        pc_i = 24'h000101; #1;
        check(next_pc_o == 24'h000102, "R7", "inside block sequential", next_pc_o, 24'h000102);
        pc_i = 24'h000103; #1;
        check(next_pc_o == 24'h000100, "R4", "redirect at last", next_pc_o, 24'h000100);
        run_block(24'h000100, 24'h000103, 2, "R5");
    endtask

    task automatic t_zero_count;
        load_block(24'h000180, 24'h000182, 32'd0);
        pc_i = 24'h000182; #1;
        check(next_pc_o == 24'h000183, "R6", "zero count falls through", next_pc_o, 24'h000183);
        run_block(24'h000180, 24'h000182, 0, "R6");
    endtask

    task automatic t_single;
        load_block(24'h000200, 24'h000200, 32'd4);
        run_block(24'h000200, 24'h000200, 4, "R9");
    endtask

    task automatic t_nostep;
        load_block(24'h000600, 24'h000601, 32'd1);
        step_i = 1'b0;
        pc_i = 24'h000601;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
        end
        #1;
        check(rpt_active_o == 1'b1, "R8", "mode held without step", rpt_active_o, 1);
        check(next_pc_o == 24'h000600, "R8", "count held without step", next_pc_o, 24'h000600);
        run_block(24'h000600, 24'h000601, 1, "R8");
    endtask

    task automatic t_collide;
        load_block(24'h000400, 24'h000402, 32'd5);
        pc_i = 24'h000402; step_i = 1'b1;
        ld_i = 1'b1; ld_first_i = 24'h000500; ld_last_i = 24'h000501; ld_reps_i = 32'd0;
        #1;
        check(next_pc_o == 24'h000400, "R10", "same-cycle route follows old block", next_pc_o, 24'h000400);
        @(posedge clk); @(negedge clk);
        ld_i = 1'b0; step_i = 1'b0;
        check(rpt_active_o == 1'b1, "R10", "mode after colliding load", rpt_active_o, 1);
        pc_i = 24'h000402; #1;
        check(next_pc_o == 24'h000403, "R10", "old last no longer matches", next_pc_o, 24'h000403);
        run_block(24'h000500, 24'h000501, 0, "R10");
    endtask

    task automatic t_wrap;
        load_block(24'hFFFFFE, 24'hFFFFFF, 32'd0);
        pc_i = 24'hFFFFFF; #1;
        check(next_pc_o == 24'h000000, "R11", "wrap on fall-through", next_pc_o, 0);
        run_block(24'hFFFFFE, 24'hFFFFFF, 0, "R11");
    endtask

    initial begin
        rst = 1'b1; step_i = 1'b0; ld_i = 1'b0; pc_i = '0;
        ld_first_i = '0; ld_last_i = '0; ld_reps_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_basic();
        t_zero_count();
        t_single();
        t_nostep();
        t_collide();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule